// File: doc/BRIEF.md
# I2C Event Flag Status Controller

This block keeps the event flags and the interrupt request that software sees on the status side of an I2C peripheral. A separate bus engine reports what happens on the wire as single-cycle pulses: the own address was matched, a byte finished, the master did not acknowledge a transmitted byte, or a stop condition appeared. The block turns those pulses into sticky flags, combines them into one summary event flag, and raises an interrupt line when that summary flag is set and interrupts are enabled.

Flags are not written to clear. Each one clears only when software performs the register accesses that belong to it. The byte-finished flag needs a read of the first status register and then, in a later cycle, the data access that matches the transfer direction. A DMA-complete pulse also clears it. After an acknowledge failure, software can clear the byte-finished flag by writing the data register, or it can release the lines by pulsing a stop-control bit. In the second case the next stop event is swallowed.

Top module: `i2c_evt_status`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every flag, the summary flag and the interrupt output by the first clock edge. It also clears the arming state and the release state.
- R2: `ev_addr_match` sets `flag_addr_sel` at the next edge. A `rd_stat1` strobe clears it.
- R3: In receive mode (`xfer_tx` = 0), `ev_byte_done` sets `flag_byte_done`. The flag clears only when a `rd_stat1` strobe is followed, in a later cycle, by a `rd_data` strobe. A `rd_data` strobe with no earlier status read, or a `wr_data` strobe, leaves the flag set.
- R4: In transmit mode (`xfer_tx` = 1), `flag_byte_done` clears only when a `rd_stat1` strobe is followed, in a later cycle, by a `wr_data` strobe. A `rd_data` strobe does not clear it.
- R5: A new `ev_byte_done` that arrives between the status read and the data access cancels the arming. The data access then leaves `flag_byte_done` set.
- R6: A `dma_done` pulse clears `flag_byte_done` with no status read needed.
- R7: `ev_ack_fail` sets both `flag_ack_fail` and `flag_byte_done`. A `rd_stat1` strobe clears `flag_ack_fail` and leaves `flag_byte_done` set.
- R8: While `flag_byte_done` is held by an acknowledge failure, a `wr_data` strobe clears it, even with no status read before it.
- R9: While `flag_byte_done` is held by an acknowledge failure, driving `stop_ctl` high and then low clears it on the falling step. The next `ev_stop` then does not set `flag_stop`. A later `ev_stop` does set it.
- R10: `ev_stop` sets `flag_stop`. A `rd_stat2` strobe clears it.
- R11: `flag_event` is the OR of the four flags, and it falls in the same cycle that the last pending flag clears. `irq` equals `flag_event` when `irq_en` = 1, and it is 0 when `irq_en` = 0.
- R12: When a set event and a clearing access for the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_addr_match | input | 1 | Pulse: own address recognised |
| ev_byte_done | input | 1 | Pulse: byte transfer finished |
| ev_ack_fail | input | 1 | Pulse: master did not acknowledge a sent byte |
| ev_stop | input | 1 | Pulse: stop condition detected |
| xfer_tx | input | 1 | Transfer direction, 1 = transmit, 0 = receive |
| rd_stat1 | input | 1 | Strobe: first status register read |
| rd_stat2 | input | 1 | Strobe: second status register read |
| rd_data | input | 1 | Strobe: data register read |
| wr_data | input | 1 | Strobe: data register write |
| dma_done | input | 1 | Pulse: DMA transfer complete |
| stop_ctl | input | 1 | Stop-control bit level, used to release the lines |
| irq_en | input | 1 | Interrupt enable |
| flag_addr_sel | output | 1 | Address-selected flag |
| flag_byte_done | output | 1 | Byte-transfer-finished flag |
| flag_ack_fail | output | 1 | Acknowledge-failure flag |
| flag_stop | output | 1 | Stop-detected flag |
| flag_event | output | 1 | Summary event flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the swallowed stop. It needs an acknowledge failure to be pending, then a full high-then-low pulse on the stop-control level, then a stop pulse. After that, a second stop must still be recorded. The stimulus table walks that exact sequence row by row. A directed reset in the middle of an armed, released state then shows that none of the hidden state survives. The disarming case also depends on ordering: a second byte event placed between the status read and the data read.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    // number of flags that set on one event and clear on one strobe
    localparam int unsigned STICKY_N = 3;
    localparam int unsigned IX_ADDR  = 0;
    localparam int unsigned IX_ACKF  = 1;
    localparam int unsigned IX_STOP  = 2;

    typedef struct packed {
        logic btf;      // byte-finished flag
        logic arm;      // status read seen, waiting for data access
        logic from_af;  // flag is held because of an acknowledge failure
    } btf_st_t;

    typedef struct packed {
        logic sup;      // swallow next stop event
        logic ctl;      // stop-control level of previous cycle
    } rel_st_t;

endpackage

// File: rtl/evt_sticky_flag.sv
module evt_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set has priority
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R12: a set in the same cycle as a clear is never lost
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R2/R10: a lone clear strobe drops the flag
    a_r10_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/evt_btf_track.sv
module evt_btf_track
    import i2c_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_byte_i,
    input  logic ev_af_i,
    input  logic xfer_tx_i,
    input  logic rd_stat1_i,
    input  logic rd_data_i,
    input  logic wr_data_i,
    input  logic dma_done_i,
    input  logic release_i,
    output logic btf_o,
    output logic from_af_o
);
    btf_st_t st_d, st_q;
    logic    set_ev, dr_hit, clr_ev;

    always_comb begin
        set_ev = ev_byte_i | ev_af_i;
        dr_hit = xfer_tx_i ? wr_data_i : rd_data_i;
        clr_ev = dma_done_i
               | (st_q.arm & dr_hit)
               | (st_q.from_af & (wr_data_i | release_i));

        st_d = st_q;
        if (set_ev) begin
            st_d.btf     = 1'b1;
            st_d.from_af = ev_af_i;
            st_d.arm     = 1'b0;
        end else begin
            if (clr_ev) begin
                st_d.btf     = 1'b0;
                st_d.from_af = 1'b0;
                st_d.arm     = 1'b0;
            end
            if (rd_stat1_i) st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign btf_o     = st_q.btf;
    assign from_af_o = st_q.from_af;

    // R5: a fresh byte event cancels any pending arming
    a_r5_new_byte_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_i |=> !st_q.arm);
    // R6: DMA completion clears unless a new event arrives
    a_r6_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done_i && !ev_byte_i && !ev_af_i) |=> !btf_o);
    // R3/R4: an unarmed, non-AF data access without DMA keeps the flag
    a_r3_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (btf_o && !st_q.arm && !st_q.from_af && !dma_done_i) |=> btf_o);
    // R8: ack-fail flag state implies the byte flag
    a_r8_af_implies_btf: assert property (@(posedge clk) disable iff (!rst_n)
        from_af_o |-> btf_o);
endmodule

// File: rtl/evt_release_guard.sv
module evt_release_guard
    import i2c_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_ctl_i,
    input  logic af_pending_i,
    input  logic ev_stop_i,
    output logic release_o,
    output logic stop_set_o
);
    rel_st_t st_d, st_q;
    logic    ctl_fall;

    always_comb begin
        ctl_fall   = st_q.ctl & ~stop_ctl_i;
        release_o  = ctl_fall & af_pending_i;
        stop_set_o = ev_stop_i & ~st_q.sup;

        st_d     = st_q;
        st_d.ctl = stop_ctl_i;
        if (ev_stop_i) st_d.sup = 1'b0;
        if (release_o) st_d.sup = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a release arms the swallow of exactly one stop event
    a_r9_release_arms: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> st_q.sup);
    a_r9_swallow_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sup && ev_stop_i && !release_o) |=> !st_q.sup);
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
    import i2c_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_addr_match,
    input  logic ev_byte_done,
    input  logic ev_ack_fail,
    input  logic ev_stop,
    input  logic xfer_tx,
    input  logic rd_stat1,
    input  logic rd_stat2,
    input  logic rd_data,
    input  logic wr_data,
    input  logic dma_done,
    input  logic stop_ctl,
    input  logic irq_en,
    output logic flag_addr_sel,
    output logic flag_byte_done,
    output logic flag_ack_fail,
    output logic flag_stop,
    output logic flag_event,
    output logic irq
);
    logic [STICKY_N-1:0] sticky_set, sticky_clr, sticky_q;
    logic btf, from_af, line_release, stop_set;

    evt_release_guard u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_ctl_i   (stop_ctl),
        .af_pending_i (from_af),
        .ev_stop_i    (ev_stop),
        .release_o    (line_release),
        .stop_set_o   (stop_set)
    );

    evt_btf_track u_btf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_byte_i  (ev_byte_done),
        .ev_af_i    (ev_ack_fail),
        .xfer_tx_i  (xfer_tx),
        .rd_stat1_i (rd_stat1),
        .rd_data_i  (rd_data),
        .wr_data_i  (wr_data),
        .dma_done_i (dma_done),
        .release_i  (line_release),
        .btf_o      (btf),
        .from_af_o  (from_af)
    );

    always_comb begin
        sticky_set          = '0;
        sticky_clr          = '0;
        sticky_set[IX_ADDR] = ev_addr_match;
        sticky_clr[IX_ADDR] = rd_stat1;
        sticky_set[IX_ACKF] = ev_ack_fail;
        sticky_clr[IX_ACKF] = rd_stat1;
        sticky_set[IX_STOP] = stop_set;
        sticky_clr[IX_STOP] = rd_stat2;
    end

    for (genvar gi = 0; gi < STICKY_N; gi++) begin : g_sticky
        evt_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (sticky_set[gi]),
            .clr_i  (sticky_clr[gi]),
            .flag_o (sticky_q[gi])
        );
    end

    assign flag_addr_sel  = sticky_q[IX_ADDR];
    assign flag_ack_fail  = sticky_q[IX_ACKF];
    assign flag_stop      = sticky_q[IX_STOP];
    assign flag_byte_done = btf;
    assign flag_event     = (|sticky_q) | btf;
    assign irq            = flag_event & irq_en;

    // R1: reset leaves nothing pending
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !flag_event);
    // R2: address match shows up one edge later
    a_r2_addr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_match |=> flag_addr_sel);
    // R7: ack failure raises both its own flag and the byte flag
    a_r7_af_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack_fail |=> (flag_ack_fail && flag_byte_done));
    // R10: unsuppressed stop sets the stop flag
    a_r10_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !$past(line_release) && !flag_stop && stop_set) |=> flag_stop);
    // R11: no interrupt without a pending event or without enable
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_event || !irq_en) |-> !irq);
endmodule

// File: tb/i2c_evt_status_test.sv
`timescale 1ns/1ps
module i2c_evt_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_addr_match = 0, ev_byte_done = 0, ev_ack_fail = 0, ev_stop = 0;
    logic xfer_tx = 0, rd_stat1 = 0, rd_stat2 = 0, rd_data = 0, wr_data = 0;
    logic dma_done = 0, stop_ctl = 0, irq_en = 0;
    logic flag_addr_sel, flag_byte_done, flag_ack_fail, flag_stop, flag_event, irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    i2c_evt_status uut (.*);

    // stimulus bits [17:6]: irq_en stop_ctl tx dma wr rd_d rd2 rd1 ev_stop ev_af ev_bd ev_am
    // expected bits [5:0]: irq evf stopf af btf adsl
    localparam int NV = 41;
    localparam logic [17:0] VEC [NV] = '{
        {12'b1000_0000_0001, 6'b110001},  // R2 addr match
        {12'b1000_0001_0000, 6'b000000},  // R2 stat1 clears
        {12'b1000_0000_0010, 6'b110010},  // R3 rx byte (disarms)
        {12'b1000_0100_0000, 6'b110010},  // R3 unarmed data read keeps
        {12'b1000_0001_0000, 6'b110010},  // R3 arm
        {12'b1000_1000_0000, 6'b110010},  // R3 write in rx keeps
        {12'b1000_0100_0000, 6'b000000},  // R3 armed read clears
        {12'b1000_0000_0010, 6'b110010},  // R5 byte
        {12'b1000_0001_0000, 6'b110010},  // R5 arm
        {12'b1000_0000_0010, 6'b110010},  // R5 new byte disarms
        {12'b1000_0100_0000, 6'b110010},  // R5 read does not clear
        {12'b1001_0000_0000, 6'b000000},  // R6 dma clears
        {12'b1010_0000_0010, 6'b110010},  // R4 tx byte
        {12'b1010_0001_0000, 6'b110010},  // R4 arm
        {12'b1010_0100_0000, 6'b110010},  // R4 read in tx keeps
        {12'b1010_1000_0000, 6'b000000},  // R4 write clears
        {12'b0000_0000_1000, 6'b011000},  // R11 stop with irq disabled
        {12'b1000_0000_0000, 6'b111000},  // R11 irq follows enable
        {12'b1000_0010_0000, 6'b000000},  // R10 stat2 clears
        {12'b1010_0000_0100, 6'b110110},  // R7 ack fail sets af+btf
        {12'b1010_0001_0000, 6'b110010},  // R7 stat1 clears af only
        {12'b1010_1000_0000, 6'b000000},  // R8 write clears
        {12'b1010_0000_0100, 6'b110110},  // R8 ack fail
        {12'b1010_1000_0000, 6'b110100},  // R8 write clears btf without arm
        {12'b1010_0001_0000, 6'b000000},  // R7 stat1 clears af
        {12'b1010_0000_0100, 6'b110110},  // R9 ack fail
        {12'b1110_0000_0000, 6'b110110},  // R9 stop_ctl high
        {12'b1010_0000_0000, 6'b110100},  // R9 stop_ctl low clears btf
        {12'b1010_0000_1000, 6'b110100},  // R9 stop swallowed
        {12'b1010_0001_0000, 6'b000000},  // R9 clear af
        {12'b1010_0000_1000, 6'b111000},  // R9 later stop recorded
        {12'b1010_0010_0000, 6'b000000},  // R10 clear
        {12'b1000_0001_0001, 6'b110001},  // R12 addr set beats clear
        {12'b1000_0001_0000, 6'b000000},  // R12 clear
        {12'b1000_0010_1000, 6'b111000},  // R12 stop set beats clear
        {12'b1000_0010_0000, 6'b000000},  // R12 clear
        {12'b1001_0000_0010, 6'b110010},  // R12 byte beats dma
        {12'b1001_0000_0000, 6'b000000},  // R6 clear
        {12'b1000_0000_1001, 6'b111001},  // R11 two flags
        {12'b1000_0001_0000, 6'b111000},  // R11 evf stays while stop pending
        {12'b1000_0010_0000, 6'b000000}   // R11 evf drops with last flag
    };
    localparam int REQ [NV] = '{2,2,3,3,3,3,3,5,5,5,5,6,4,4,4,4,11,11,10,7,7,8,8,8,7,
                                9,9,9,9,9,9,10,12,12,12,12,12,6,11,11,11};

    function automatic logic [5:0] outs();
        return {irq, flag_event, flag_stop, flag_ack_fail, flag_byte_done, flag_addr_sel};
    endfunction

    task automatic apply(input logic [11:0] s);
        {irq_en, stop_ctl, xfer_tx, dma_done, wr_data, rd_data, rd_stat2, rd_stat1,
         ev_stop, ev_ack_fail, ev_byte_done, ev_addr_match} = s;
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        n_checks++;
        if (outs() !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, outs(), exp);
        end
    endtask

    initial begin
        // R1: reset state
        rst_n = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1 reset", 6'b000000);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:6]);
            @(posedge clk); #1;
            check($sformatf("R%0d row %0d", REQ[i], i), VEC[i][5:0]);
        end
        // R1: reset mid-run while armed and release pending
        apply(12'b1010_0000_0101);
        @(posedge clk); #1;
        apply(12'b1110_0001_0000);
        @(posedge clk); #1;
        apply(12'b1010_0000_0000);
        rst_n = 0;
        @(posedge clk); #1;
        check("R1 mid-run reset", 6'b000000);
        rst_n = 1;
        apply(12'b1010_0000_1000);           // stop must not be swallowed after reset
        @(posedge clk); #1;
        check("R1 release state cleared", 6'b111000);
        apply(12'b1010_0010_0000);
        @(posedge clk); #1;
        // R9: stop_ctl pulse without ack failure has no effect
        apply(12'b1010_0000_0010);
        @(posedge clk); #1;
        apply(12'b1110_0000_0000);
        @(posedge clk); #1;
        apply(12'b1010_0000_0000);
        @(posedge clk); #1;
        check("R9 no release without af", 6'b110010);
        apply(12'b1010_0000_1000);
        @(posedge clk); #1;
        check("R9 stop kept without af", 6'b111010);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule